// File: doc/BRIEF.md
# Scheduled Pulse-Per-Second Generator

This block produces a single narrow pulse after a delay that a host programs in ticks. The host pushes a 32-bit tick count through a valid/ready write port into a small queue. When the block is idle it takes the oldest queued count, loads it into a down-counter and decrements it once per tick, where a tick is a fixed number of base clock cycles. When the countdown runs out, the block drives its output high for a fixed number of base cycles. It then returns to idle and waits for the next count.

The host works out how many ticks remain until the next second boundary and queues that number. After that the pulse timing depends only on the count and the tick rate. Nothing the host does after the load can move the edge. The block never fires on its own. Each accepted count gives exactly one pulse.

Top module: `sched_pulse_gen`

## Requirements
- R1: With no count queued, the block stays idle: `busy_o` is low and `pulse_o` never rises.
- R2: For a count N ≥ 1 accepted at clock edge Ew while the block is idle with an empty queue, `pulse_o` rises at edge Ew + 1 + N·TICK_DIV.
- R3: Each pulse stays high for exactly PULSE_CYCLES base clock cycles and then returns low.
- R4: Counts of 0 and 1 both fire after a single tick, so the pulse rises at Ew + 1 + TICK_DIV. A zero count never wraps through 2^32.
- R5: Each accepted count produces exactly one pulse, and `busy_o` falls in the same cycle that the pulse ends.
- R6: A count accepted while a countdown or pulse is in progress is held in the queue. Its countdown starts only after the current pulse ends, so its pulse rises at P + PULSE_CYCLES + 1 + N·TICK_DIV, where P is the rising edge of the previous pulse.
- R7: `cnt_ready_o` is low exactly when FIFO_DEPTH counts are queued. A write presented while it is low is ignored and produces no pulse.
- R8: Asserting `rst_n` low clears the countdown and the queue. Afterwards `pulse_o` and `busy_o` are low, `cnt_ready_o` is high, and no count queued before the reset ever fires.
- R9: `busy_o` is high from the cycle after a count is taken from the queue through the last high cycle of its pulse, and `pulse_o` is never high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronously outside the block |
| cnt_valid_i | input | 1 | Host offers a count |
| cnt_data_i | input | COUNT_W | Tick count for the next pulse |
| cnt_ready_o | output | 1 | Queue can accept a count |
| busy_o | output | 1 | Countdown or pulse in progress |
| pulse_o | output | 1 | Timed output pulse |

## Verification
The bench builds the block with TICK_DIV = 3, PULSE_CYCLES = 8 and FIFO_DEPTH = 4. This gives a three-cycle tick and an eight-cycle pulse, so every rise and fall edge can be predicted exactly from the count. It also lets five counts stay in flight at once, one counting down and four queued, so the queue-full stall and the ignored write are easy to reach. Counts stay small so that the delays fit a short run. The full 32-bit range appears only through the zero-count case and the load width.

// File: rtl/sched_pulse_gen_pkg.sv
package sched_pulse_gen_pkg;
  typedef enum logic [1:0] {
    SPG_IDLE  = 2'd0,
    SPG_COUNT = 2'd1,
    SPG_PULSE = 2'd2
  } spg_state_e;
endpackage

// File: rtl/spg_count_fifo.sv
module spg_count_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr, wr_ptr_nxt, rd_ptr_nxt;
  logic [OW-1:0]    occ, occ_nxt;
  logic             do_push, do_pop;

  assign empty   = (occ == '0);
  assign full    = (occ == OW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_comb begin
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    occ_nxt    = occ;
    if (do_push) wr_ptr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    if (do_pop)  rd_ptr_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    if (do_push && !do_pop)      occ_nxt = occ + 1'b1;
    else if (!do_push && do_pop) occ_nxt = occ - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      occ    <= occ_nxt;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (do_push && (wr_ptr == AW'(i))) mem[i] <= push_data;
      end
    end
  endgenerate
endmodule

// File: rtl/spg_tick_gen.sv
module spg_tick_gen #(
  parameter int TICK_DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every_cycle
      assign tick = run;
    end else begin : g_prescale
      localparam int PW = $clog2(TICK_DIV);
      logic [PW-1:0] pre, pre_nxt;
      logic          wrap;

      assign wrap = (pre == PW'(TICK_DIV - 1));
      assign tick = run && wrap;

      always_comb begin
        pre_nxt = pre;
        if (!run)      pre_nxt = '0;
        else if (wrap) pre_nxt = '0;
        else           pre_nxt = pre + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre <= '0;
        else        pre <= pre_nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/spg_countdown.sv
module spg_countdown
  import sched_pulse_gen_pkg::*;
#(
  parameter int COUNT_W      = 32,
  parameter int PULSE_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               q_empty,
  input  logic [COUNT_W-1:0] q_head,
  input  logic               tick,
  output logic               q_pop,
  output logic               counting,
  output logic               busy,
  output logic               pulse
);
  localparam int WW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;

  spg_state_e         state, state_nxt;
  logic [COUNT_W-1:0] remain, remain_nxt;
  logic [WW-1:0]      width, width_nxt;
  logic               pulse_q, pulse_nxt;
  logic               last_tick, last_width;

  assign last_tick  = (remain <= COUNT_W'(1));
  assign last_width = (width == WW'(PULSE_CYCLES - 1));

  always_comb begin
    state_nxt  = state;
    remain_nxt = remain;
    width_nxt  = width;
    pulse_nxt  = pulse_q;
    q_pop      = 1'b0;
    unique case (state)
      SPG_IDLE: begin
        if (!q_empty) begin
          q_pop      = 1'b1;
          remain_nxt = q_head;
          state_nxt  = SPG_COUNT;
        end
      end
      SPG_COUNT: begin
        if (tick) begin
          if (last_tick) begin
            state_nxt  = SPG_PULSE;
            width_nxt  = '0;
            pulse_nxt  = 1'b1;
            remain_nxt = '0;
          end else begin
            remain_nxt = remain - 1'b1;
          end
        end
      end
      SPG_PULSE: begin
        if (last_width) begin
          state_nxt = SPG_IDLE;
          pulse_nxt = 1'b0;
        end else begin
          width_nxt = width + 1'b1;
        end
      end
      default: begin
        state_nxt = SPG_IDLE;
        pulse_nxt = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SPG_IDLE;
      remain  <= '0;
      width   <= '0;
      pulse_q <= 1'b0;
    end else begin
      state   <= state_nxt;
      remain  <= remain_nxt;
      width   <= width_nxt;
      pulse_q <= pulse_nxt;
    end
  end

  assign counting = (state == SPG_COUNT);
  assign busy     = (state != SPG_IDLE);
  assign pulse    = pulse_q;
endmodule

// File: rtl/sched_pulse_gen.sv
module sched_pulse_gen #(
  parameter int COUNT_W      = 32,
  parameter int FIFO_DEPTH   = 4,
  parameter int TICK_DIV     = 3,
  parameter int PULSE_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_valid_i,
  input  logic [COUNT_W-1:0] cnt_data_i,
  output logic               cnt_ready_o,
  output logic               busy_o,
  output logic               pulse_o
);
  logic               fifo_pop, fifo_empty, fifo_full;
  logic [COUNT_W-1:0] fifo_head;
  logic               tick, counting;

  spg_count_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(COUNT_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (cnt_valid_i),
    .push_data (cnt_data_i),
    .pop       (fifo_pop),
    .head      (fifo_head),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  spg_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (counting),
    .tick  (tick)
  );

  spg_countdown #(.COUNT_W(COUNT_W), .PULSE_CYCLES(PULSE_CYCLES)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .q_empty  (fifo_empty),
    .q_head   (fifo_head),
    .tick     (tick),
    .q_pop    (fifo_pop),
    .counting (counting),
    .busy     (busy_o),
    .pulse    (pulse_o)
  );

  assign cnt_ready_o = !fifo_full;
endmodule

// File: rtl/sched_pulse_gen_chk.sv
module sched_pulse_gen_chk #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input logic clk,
  input logic rst_n,
  input logic cnt_valid_i,
  input logic cnt_ready_o,
  input logic busy_o,
  input logic pulse_o,
  input logic pop
);
  localparam int OW = $clog2(DEPTH + 1) + 1;
  localparam int HW = $clog2(WIDTH + 1) + 1;

  logic [OW-1:0] occ;
  logic [HW-1:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ    <= '0;
      hi_run <= '0;
    end else begin
      occ    <= occ + OW'(cnt_valid_i && cnt_ready_o) - OW'(pop);
      hi_run <= pulse_o ? hi_run + 1'b1 : '0;
    end
  end

  // R3: pulse ends after exactly WIDTH high cycles
  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_o) |-> (hi_run == HW'(WIDTH)));

  // R3: pulse never stays high past WIDTH cycles
  assert_pulse_not_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (hi_run < HW'(WIDTH)));

  // R1: an idle block cannot raise the pulse in the next cycle
  assert_idle_no_fire_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> !pulse_o);

  // R9: pulse implies busy
  assert_pulse_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> busy_o);

  // R5: busy ends together with the pulse
  assert_busy_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_o) |-> !busy_o);

  // R7: ready low only when the queue holds DEPTH counts
  assert_ready_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_ready_o |-> (occ == OW'(DEPTH)));

  // R7: queue occupancy never exceeds DEPTH
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(DEPTH));
endmodule

bind sched_pulse_gen sched_pulse_gen_chk #(.DEPTH(FIFO_DEPTH), .WIDTH(PULSE_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cnt_valid_i (cnt_valid_i),
  .cnt_ready_o (cnt_ready_o),
  .busy_o      (busy_o),
  .pulse_o     (pulse_o),
  .pop         (fifo_pop)
);

// File: tb/sched_pulse_gen_tb.sv
module sched_pulse_gen_tb;
  localparam int CW  = 32;
  localparam int DEP = 4;
  localparam int DIV = 3;
  localparam int PW  = 8;

  logic          clk;
  logic          rst_n;
  logic          cnt_valid_i;
  logic [CW-1:0] cnt_data_i;
  logic          cnt_ready_o;
  logic          busy_o;
  logic          pulse_o;

  int cyc;
  int n_tests;
  int n_fail;

  sched_pulse_gen #(.COUNT_W(CW), .FIFO_DEPTH(DEP), .TICK_DIV(DIV), .PULSE_CYCLES(PW)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_valid_i (cnt_valid_i),
    .cnt_data_i  (cnt_data_i),
    .cnt_ready_o (cnt_ready_o),
    .busy_o      (busy_o),
    .pulse_o     (pulse_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_tests = n_tests + 1;
      n_fail  = n_fail + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one write, returns the edge index it was offered at and whether ready was high
  task automatic write_count(input int val, output int wedge, output bit taken);
    @(negedge clk);
    cnt_valid_i = 1'b1;
    cnt_data_i  = CW'(val);
    taken       = cnt_ready_o;
    @(negedge clk);
    wedge       = cyc;
    cnt_valid_i = 1'b0;
  endtask

  // wait for rising pulse, return its edge index (or -1) and width
  task automatic wait_pulse(input int limit, output int rise, output int wid);
    rise = -1;
    wid  = 0;
    for (int i = 0; i < limit; i++) begin
      if (pulse_o) begin
        rise = cyc;
        break;
      end
      @(negedge clk);
    end
    if (rise >= 0) begin
      while (pulse_o && wid < 64) begin
        wid++;
        @(negedge clk);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    check(pulse_o == 1'b0, "R8 pulse after reset", pulse_o, 0);
    check(busy_o == 1'b0, "R8 busy after reset", busy_o, 0);
    check(cnt_ready_o == 1'b1, "R8 ready after reset", cnt_ready_o, 1);
  endtask

  task automatic t_idle();
    int highs = 0, busys = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (pulse_o) highs++;
      if (busy_o)  busys++;
    end
    check(highs == 0, "R1 no pulse when idle", highs, 0);
    check(busys == 0, "R1 busy low when idle", busys, 0);
  endtask

  task automatic t_single(input int n);
    int w, r, wd;
    bit tk;
    write_count(n, w, tk);
    check(tk, "R2 write accepted", tk, 1);
    @(negedge clk);
    check(busy_o == 1'b1, "R9 busy during countdown", busy_o, 1);
    wait_pulse(n * DIV + 40, r, wd);
    check(r == w + 1 + n * DIV, "R2 pulse delay", r - w, 1 + n * DIV);
    check(wd == PW, "R3 pulse width", wd, PW);
    check(busy_o == 1'b0, "R5 busy falls with pulse", busy_o, 0);
  endtask

  task automatic t_small(input int n);
    int w, r, wd;
    bit tk;
    write_count(n, w, tk);
    wait_pulse(40, r, wd);
    check(r == w + 1 + DIV, "R4 small count fires after one tick", r - w, 1 + DIV);
    check(wd == PW, "R3 small count width", wd, PW);
  endtask

  task automatic t_back_to_back();
    int w1, w2, r1, r2, wd1, wd2;
    bit tk;
    write_count(4, w1, tk);
    write_count(2, w2, tk);
    check(tk, "R6 queued write accepted", tk, 1);
    wait_pulse(80, r1, wd1);
    check(r1 == w1 + 1 + 4 * DIV, "R6 first pulse", r1 - w1, 1 + 4 * DIV);
    wait_pulse(80, r2, wd2);
    check(r2 == r1 + PW + 1 + 2 * DIV, "R6 held count starts after pulse", r2 - r1, PW + 1 + 2 * DIV);
    check(wd2 == PW, "R3 second pulse width", wd2, PW);
  endtask

  task automatic t_fifo_full();
    int w, pulses = 0;
    bit tk, rdy_seen;
    logic prev = 1'b0;
    write_count(10, w, tk);
    @(negedge clk);
    for (int i = 0; i < DEP; i++) write_count(1, w, tk);
    check(cnt_ready_o == 1'b0, "R7 ready low when full", cnt_ready_o, 0);
    @(negedge clk);
    cnt_valid_i = 1'b1;
    cnt_data_i  = CW'(1);
    rdy_seen    = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (cnt_ready_o) rdy_seen = 1'b1;
      @(negedge clk);
    end
    cnt_valid_i = 1'b0;
    check(!rdy_seen, "R7 ready stays low while full", rdy_seen, 0);
    for (int i = 0; i < 300; i++) begin
      if (pulse_o && !prev) pulses++;
      prev = pulse_o;
      @(negedge clk);
    end
    check(pulses == DEP + 1, "R7 ignored write adds no pulse / R5 one per count", pulses, DEP + 1);
    check(busy_o == 1'b0, "R5 idle after last pulse", busy_o, 0);
  endtask

  task automatic t_reset_mid();
    int w, highs = 0;
    bit tk;
    write_count(50, w, tk);
    write_count(3, w, tk);
    repeat (10) @(negedge clk);
    do_reset();
    check(cnt_ready_o == 1'b1, "R8 ready after mid reset", cnt_ready_o, 1);
    for (int i = 0; i < 300; i++) begin
      if (pulse_o || busy_o) highs++;
      @(negedge clk);
    end
    check(highs == 0, "R8 discarded counts never fire", highs, 0);
  endtask

  initial begin
    n_tests     = 0;
    n_fail      = 0;
    cyc         = 0;
    rst_n       = 1'b0;
    cnt_valid_i = 1'b0;
    cnt_data_i  = '0;
    t_reset_state();
    t_idle();
    t_single(5);
    t_single(20);
    t_small(0);
    t_small(1);
    t_back_to_back();
    t_fifo_full();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule